// File: doc/BRIEF.md
# Buffered Compare-Match Interval Timer

This block is a pair of 8-bit up-counters. Each one counts enabled clock cycles and compares its count against a compare latch. Software never writes the latch directly. It writes a data register, and the latch copies that register only when the timer starts and on every match. A write made during a running period therefore takes effect only after that period ends. Programming a value V gives a period of V+1 count events. Each match clears the counter and counting carries on.

Each channel takes its count enable from one of two sources: a prescaled tick input, or an asynchronous event input. The event input passes through a synchronizer and a rising-edge detector before it is used. The two channels can also be joined into one 16-bit timer. Channel 0 then holds the low byte and channel 1 the high byte. A match produces a one-cycle pulse on the match output and sets a sticky flag, and an enable bit per channel passes the flag to the interrupt output.

Each channel has its own run controller with three states. IDLE is the state after reset. RUN counts. HOLD is stopped, with the count frozen. The transitions are:
- IDLE→RUN, named *launch*, and HOLD→RUN, named *relaunch*: both happen when the start bit is 1, and both clear the counter and load the latch.
- RUN→HOLD, named *halt*: happens when the start bit is 0.
- Every other case stays in the current state.

Top module: `cmp_interval_timer`

## Requirements
- R1: After reset, every readable address returns 0, and match_o and irq_o are low.
- R2: The register map is as follows:
  - Address 0 is channel 0 data and address 1 is channel 1 data. Both are read/write.
  - Address 2 is control. Bit 0 is start0, bit 1 is start1, bit 2 joins the channels into 16-bit mode, bit 3 is src0 and bit 4 is src1 (1 selects the event input), bit 5 is ie0 and bit 6 is ie1. Bit 7 reads 0.
  - Address 3 holds the flags: flag0 in bit 0 and flag1 in bit 1.
  - Addresses 4 and 5 return the counts of channel 0 and channel 1. They are read-only, and writes to them are ignored.
  - Addresses 6 and 7 read 0.
- R3: Suppose a write sets the start bit at clock edge W. Then at edge W+1 the counter clears and the latch loads from the data register. Counting begins at edge W+2.
- R4: At an enabled count event, if the counter equals the latch, the counter clears and the channel matches. Otherwise the counter increments. With a tick on every cycle and value V, the first match comes at edge W+2+V and each later match V+1 edges after the one before.
- R5: A data-register write made while the channel runs leaves the current period unchanged. The new value sets the period only after the next match.
- R6: Once the start bit is 0, the counter stops at the next edge and keeps its value. Count events have no effect while the channel is stopped.
- R7: Setting the start bit again after a stop clears the counter and reloads the latch before counting resumes.
- R8: In 16-bit mode, the compare value is data1:data0 and the count carries from channel 0 into channel 1. Only match_o[0] and flag0 report the match; match_o[1] stays low.
- R9: In event mode, a rising edge of evt_i is counted at the third clock edge after it rises. An input held high counts only once, and tick_i is ignored.
- R10: Each match produces match_o high for exactly one cycle, after the matching edge, and sets the channel's flag.
- R11: A flag stays set until software writes 0 to its bit at address 3. Writing 1 to the bit leaves the flag unchanged.
- R12: irq_o is high exactly when some flag is set and its enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| tick_i | input | 2 | Prescaled count tick, one bit per channel |
| evt_i | input | 2 | Asynchronous event input, one bit per channel |
| match_o | output | 2 | One-cycle match pulse per channel |
| irq_o | output | 1 | Interrupt request |

## Verification
The interval function runs with a tick on every cycle, and the bench predicts each match at its exact cycle. A short 8-bit period shows whether the count includes the +1 and whether counting starts two edges after the start write. A data write in the middle of a period separates a double-buffered latch from one that loads immediately. A restart after a stop shows whether the counter is cleared or resumes. A 16-bit run whose value is above 255, stopped and read back partway through, exposes carry and full-width compare faults. In event mode, the tick is held high and each event is held high for several cycles, so any counting of levels or of ticks produces an early, unexpected match.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_HOLD = 2'b10
    } run_st_t;

    // register addresses
    localparam int ADR_DATA0 = 0;
    localparam int ADR_DATA1 = 1;
    localparam int ADR_CTRL  = 2;
    localparam int ADR_FLAGS = 3;
    localparam int ADR_CNT0  = 4;
    localparam int ADR_CNT1  = 5;

    // control bit positions
    localparam int CB_START0 = 0;
    localparam int CB_START1 = 1;
    localparam int CB_CASC   = 2;
    localparam int CB_SRC0   = 3;
    localparam int CB_SRC1   = 4;
    localparam int CB_IE0    = 5;
    localparam int CB_IE1    = 6;
    localparam int CTRL_W    = 7;

endpackage

// File: rtl/tmr_evt_sync.sv
module tmr_evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    logic [STAGES-1:0] sh_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            last_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], async_i};
            last_q <= sh_q[STAGES-1];
        end
    end

    // one pulse for each low-to-high change of the synchronized level
    assign rise_o = sh_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/tmr_run_fsm.sv
module tmr_run_fsm
    import tmr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start_i,
    output logic    load_o,
    output logic    run_o,
    output run_st_t state_o
);

    run_st_t st_q, st_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    // transitions: launch, relaunch, halt
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE: if (start_i)  st_nxt = ST_RUN;
            ST_RUN:  if (!start_i) st_nxt = ST_HOLD;
            ST_HOLD: if (start_i)  st_nxt = ST_RUN;
            default:               st_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_o  = 1'b0;
        run_o   = 1'b0;
        unique case (st_q)
            ST_IDLE: load_o = start_i;
            ST_RUN:  run_o  = start_i;
            ST_HOLD: load_o = start_i;
            default: begin
                load_o = 1'b0;
                run_o  = 1'b0;
            end
        endcase
        state_o = st_q;
    end

endmodule

// File: rtl/tmr_slice.sv
module tmr_slice #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] cnt_o,
    output logic         eq_o
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cmp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cmp_q <= '0;
        end else begin
            if (clr_i) begin
                cnt_q <= '0;
                cmp_q <= data_i;
            end else if (inc_i) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign cnt_o = cnt_q;
    assign eq_o  = (cnt_q == cmp_q);

endmodule

// File: rtl/cmp_interval_timer.sv
module cmp_interval_timer
    import tmr_pkg::*;
#(
    parameter int DW          = 8,
    parameter int AW          = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic [1:0]    tick_i,
    input  logic [1:0]    evt_i,
    output logic [1:0]    match_o,
    output logic          irq_o
);

    localparam int NCH = 2;

    logic [NCH-1:0][DW-1:0] data_q;
    logic [NCH-1:0]         start_q, src_q, ie_q, flag_q, match_q;
    logic                   casc_q;

    logic [NCH-1:0]         start_eff, cen, evt_rise, run_w, load_w, eq_w;
    logic [NCH-1:0]         inc_w, clr_w, wrap_w;
    logic [NCH-1:0][DW-1:0] cnt_w;
    run_st_t                st_w [NCH];

    logic                   wr_ctrl_hit, wr_flag_hit;
    logic                   hit16, step16, full0;
    logic [CTRL_W-1:0]      ctrl_vec;

    assign wr_ctrl_hit = wr_en && (wr_addr == AW'(ADR_CTRL));
    assign wr_flag_hit = wr_en && (wr_addr == AW'(ADR_FLAGS));

    // software registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            start_q <= '0;
            casc_q  <= 1'b0;
            src_q   <= '0;
            ie_q    <= '0;
        end else if (wr_en) begin
            if (wr_addr == AW'(ADR_DATA0)) data_q[0] <= wr_data;
            if (wr_addr == AW'(ADR_DATA1)) data_q[1] <= wr_data;
            if (wr_ctrl_hit) begin
                start_q[0] <= wr_data[CB_START0];
                start_q[1] <= wr_data[CB_START1];
                casc_q     <= wr_data[CB_CASC];
                src_q[0]   <= wr_data[CB_SRC0];
                src_q[1]   <= wr_data[CB_SRC1];
                ie_q[0]    <= wr_data[CB_IE0];
                ie_q[1]    <= wr_data[CB_IE1];
            end
        end
    end

    // channel 1 is slaved to channel 0 in 16-bit mode
    assign start_eff = {start_q[1] & ~casc_q, start_q[0]};

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (evt_i[g]),
            .rise_o  (evt_rise[g])
        );

        tmr_run_fsm u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (start_eff[g]),
            .load_o  (load_w[g]),
            .run_o   (run_w[g]),
            .state_o (st_w[g])
        );

        tmr_slice #(.W(DW)) u_slice (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (clr_w[g]),
            .inc_i  (inc_w[g]),
            .data_i (data_q[g]),
            .cnt_o  (cnt_w[g]),
            .eq_o   (eq_w[g])
        );

        assign cen[g] = src_q[g] ? evt_rise[g] : tick_i[g];
    end

    // compare / increment steering for the two widths
    assign hit16  = eq_w[0] & eq_w[1];
    assign step16 = run_w[0] & cen[0];
    assign full0  = &cnt_w[0];

    always_comb begin
        if (casc_q) begin
            wrap_w = {1'b0, step16 & hit16};
            inc_w  = {step16 & ~hit16 & full0, step16 & ~hit16};
            clr_w  = {NCH{load_w[0] | (step16 & hit16)}};
        end else begin
            wrap_w = run_w & cen & eq_w;
            inc_w  = run_w & cen & ~eq_w;
            clr_w  = load_w | (run_w & cen & eq_w);
        end
    end

    // match pulse and sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= '0;
            flag_q  <= '0;
        end else begin
            match_q <= wrap_w;
            for (int i = 0; i < NCH; i++) begin
                if (wrap_w[i])
                    flag_q[i] <= 1'b1;
                else if (wr_flag_hit && !wr_data[i])
                    flag_q[i] <= 1'b0;
            end
        end
    end

    assign match_o = match_q;
    assign irq_o   = |(flag_q & ie_q);

    // read path
    assign ctrl_vec = {ie_q[1], ie_q[0], src_q[1], src_q[0],
                       casc_q, start_q[1], start_q[0]};

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            AW'(ADR_DATA0): rd_data = data_q[0];
            AW'(ADR_DATA1): rd_data = data_q[1];
            AW'(ADR_CTRL):  rd_data = {{(DW-CTRL_W){1'b0}}, ctrl_vec};
            AW'(ADR_FLAGS): rd_data = {{(DW-NCH){1'b0}}, flag_q};
            AW'(ADR_CNT0):  rd_data = cnt_w[0];
            AW'(ADR_CNT1):  rd_data = cnt_w[1];
            default:        rd_data = '0;
        endcase
    end

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flag_wr,
    input logic [1:0]    flag_wdat,
    input logic [1:0]    match_o,
    input logic [1:0]    flag_q,
    input logic          irq_o,
    input logic          casc_q,
    input run_st_t       st0,
    input logic [DW-1:0] cnt0
);

    for (genvar i = 0; i < 2; i++) begin : g_flag
        // R11: a flag survives every cycle without a clearing write
        assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !(flag_wr && !flag_wdat[i])) |=> flag_q[i])
            else $error("flag %0d dropped without a clearing write", i);

        // R10: a match pulse is always accompanied by its flag
        assert_match_sets_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
            match_o[i] |-> flag_q[i])
            else $error("match %0d without flag", i);
    end

    // R8: channel 1 never reports a match while joined
    assert_cascade_ch1_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (casc_q && $past(casc_q)) |-> !match_o[1])
        else $error("channel 1 matched in 16-bit mode");

    // R6: a halted counter keeps its value
    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st0 == ST_HOLD && $past(st0) == ST_HOLD) |-> $stable(cnt0))
        else $error("counter moved while held");

    // R12: no interrupt without a pending flag
    assert_irq_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flag_q != 2'b00))
        else $error("interrupt with no flag set");

endmodule

bind cmp_interval_timer tmr_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flag_wr   (wr_flag_hit),
    .flag_wdat (wr_data[1:0]),
    .match_o   (match_o),
    .flag_q    (flag_q),
    .irq_o     (irq_o),
    .casc_q    (casc_q),
    .st0       (st_w[0]),
    .cnt0      (cnt_w[0])
);

// File: tb/sim_cmp_interval_timer.sv
`timescale 1ns/1ps
module sim_cmp_interval_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] tick_i = '0;
    logic [1:0] evt_i = '0;
    logic [1:0] match_o;
    logic       irq_o;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int exp0[$];
    int exp1[$];
    bit done = 1'b0;

    cmp_interval_timer u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .tick_i  (tick_i),
        .evt_i   (evt_i),
        .match_o (match_o),
        .irq_o   (irq_o)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a[2:0];
        wr_data = d[7:0];
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(int a, int exp, string tag);
        rd_addr = a[2:0];
        #1;
        chk(tag, int'(rd_data), exp);
    endtask

    task automatic wait_cyc(int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic evt_pulse(bit expect_match);
        if (expect_match) exp1.push_back(cyc + 3);
        evt_i[1] = 1'b1;
        repeat (3) @(negedge clk);
        evt_i[1] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // scoreboard monitor: every pulse must match the head of its queue
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (match_o[0]) begin
                if (exp0.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R10 ch0 unexpected match: actual cycle %0d expected none", cyc);
                end else begin
                    int e;
                    e = exp0.pop_front();
                    chk("R4 ch0 match cycle", cyc, e);
                end
            end
            if (match_o[1]) begin
                if (exp1.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R8/R9 ch1 unexpected match: actual cycle %0d expected none", cyc);
                end else begin
                    int e;
                    e = exp1.pop_front();
                    chk("R9 ch1 match cycle", cyc, e);
                end
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 8; a++) rd(a, 0, "R1 reset readback");
        chk("R1 match_o reset", int'(match_o), 0);
        chk("R1 irq_o reset", int'(irq_o), 0);

        // R2 register map
        wr(0, 3);
        wr(1, 8'hA5);
        wr(2, 8'hE0);
        wr(4, 8'hFF);
        rd(0, 3, "R2 data0");
        rd(1, 8'hA5, "R2 data1");
        rd(2, 8'h60, "R2 ctrl bit7 reads 0");
        rd(4, 0, "R2 cnt0 read-only");
        rd(6, 0, "R2 unused address");
        wr(2, 0);
        tick_i = 2'b11;

        // R3/R4: V=3, tick every cycle
        wr(2, 1);
        w = cyc;
        exp0.push_back(w + 5);
        exp0.push_back(w + 9);
        exp0.push_back(w + 13);
        wait_cyc(w + 13);
        wr(2, 0);
        rd(4, 2, "R6 count held after stop");
        rd(3, 1, "R10 flag0 set by match");
        repeat (10) @(negedge clk);
        rd(4, 2, "R6 ticks ignored while halted");

        // R7 restart clears counter
        wr(2, 1);
        w = cyc;
        exp0.push_back(w + 5);
        wait_cyc(w + 5);
        wr(2, 0);
        rd(4, 2, "R7 count after restart and stop");

        // R5 double buffering
        wr(0, 5);
        wr(2, 1);
        w = cyc;
        exp0.push_back(w + 7);
        exp0.push_back(w + 10);
        exp0.push_back(w + 13);
        wr(0, 2);
        wait_cyc(w + 13);
        wr(2, 0);
        rd(4, 2, "R5 count after shortened period");
        rd(0, 2, "R5 data0 readback");
        wr(3, 0);
        rd(3, 0, "R11 flags cleared by zero write");

        // R8 16-bit mode, value 300
        wr(0, 8'h2C);
        wr(1, 8'h01);
        wr(2, 8'h05);
        w = cyc;
        exp0.push_back(w + 302);
        wait_cyc(w + 302 + 257);
        wr(2, 8'h04);
        rd(4, 8'h03, "R8 low count byte");
        rd(5, 8'h01, "R8 high count byte");
        rd(3, 1, "R8 only flag0 set");
        wr(2, 0);

        // R9 event mode on channel 1, value 2, tick held high
        wr(3, 0);
        wr(1, 2);
        wr(2, 8'h12);
        evt_pulse(1'b0);
        evt_pulse(1'b0);
        evt_pulse(1'b1);
        rd(3, 2, "R9 flag1 after third event");
        chk("R12 irq masked", int'(irq_o), 0);
        wr(2, 8'h52);
        chk("R12 irq enabled", int'(irq_o), 1);
        wr(3, 8'h02);
        rd(3, 2, "R11 write one keeps flag");
        chk("R12 irq still high", int'(irq_o), 1);
        wr(3, 0);
        rd(3, 0, "R11 write zero clears flag");
        chk("R12 irq low after clear", int'(irq_o), 0);
        wr(2, 0);

        repeat (5) @(negedge clk);
        chk("R4 all expected matches seen", exp0.size() + exp1.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule